// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Slave

This block sits between a four-wire serial host link and the register state of a real-time clock. Every transaction is 64 bits long while chip select is held low. The host first shifts in a 32-bit command word. Its top bit picks the direction, and its lower 31 bits name a register. A 32-bit data word follows: the host drives it on a write, and the block drives it on a read.

The block decodes a sparse offset map. Some offsets land on registers held inside the block: two wake/sleep timer words, four test words, two control words, and a 16-word battery-backed scratch area. Two offsets land on values owned by a neighbouring seconds counter, which are a live count and a frozen snapshot. A host write to the counter is passed to that neighbour as a one-cycle load strobe carrying the data. The timer and second control words drive output ports.

The serial pins are sampled by the system clock, which must run at least four times faster than the serial clock. Edges are found by comparing each sample with the one before.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset, `miso`, `counterWrStb`, `onTimer`, `offTimer` and `ctl1` are all zero, and each of the four test words reads back as 0x03030303.
- R2: The link uses serial mode 0 with the most significant bit first. `csN` is active low. The host drives `mosi`, which is sampled on each rising `sclk`. Command bit 31 = 1 marks a write and bit 31 = 0 marks a read. Bits 63..32 of the transfer are the data word.
- R3: On a read, the data word is captured in the system-clock cycle that samples command bit 0. Its MSB appears on `miso` after the next falling `sclk`, and one bit follows per falling edge. `miso` is 0 during the command phase, during the data phase of a write, and one cycle after `csN` goes high.
- R4: The register offsets are: counter 0x20000000, snapshot 0x20400000, ON timer 0x21000000, OFF timer 0x21000100, test word j at 0x21000400 + 0x100*j (j < 4), control 0 at 0x21000C00 and control 1 at 0x21000D00. A command matches only when all of bits 30:0 are equal to the offset. Bit 31 is never part of the address.
- R5: Scratch word i (i from 0 to 15) sits at 0x20000100 + 0x100*i. Each word stores a full 32-bit value and reads it back.
- R6: Bits 7:0 of control 0 always read the REVISION parameter (default 0x01), and writes leave them unchanged. Bits 31:8 of control 0 store what the host writes.
- R7: Any offset not listed in R4 or R5 reads as zero, and a write to it changes no register. For example, 0x20000180, 0x20001100 and 0x21000200 are all unmapped.
- R8: A read of the counter returns `counterIn` as sampled in the capture cycle. A write to the counter raises `counterWrStb` for exactly one cycle, with `counterWrData` equal to the data word.
- R9: A read of the snapshot returns `snapshotIn`. A write to the snapshot has no effect and raises no strobe.
- R10: Writes to the ON timer, OFF timer and control 1 appear on `onTimer`, `offTimer` and `ctl1` in the cycle after the rising `sclk` of data bit 0. These outputs change at no other time.
- R11: If `csN` rises before the 64th bit, the transfer is aborted. No write takes place, and the next transfer starts cleanly from bit 0.
- R12: Clock edges after the 64th bit, while `csN` stays low, are ignored. Nothing is written a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| counterIn | input | 32 | Live seconds count from the neighbour |
| snapshotIn | input | 32 | Frozen count from the neighbour |
| counterWrStb | output | 1 | One-cycle load strobe for the counter |
| counterWrData | output | 32 | Load value for the counter |
| onTimer | output | 32 | ON timer word |
| offTimer | output | 32 | OFF timer word |
| ctl1 | output | 32 | Control 1 word |

## Verification
The seconds counter can advance in the very cycle that the final command bit is sampled and the read word is captured. The bench provokes this by changing `counterIn` on the same clock cycle that it raises `sclk` for command bit 0. The reference model then requires the new value, not the old one, to be shifted out. In a second case the bench issues a counter write while `counterIn` keeps moving, and requires both that the strobe fires in exactly one cycle and that a following read sees the live input.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 31;
  localparam int IDX_W  = 4;

  localparam logic [OFF_W-1:0] OFS_CNT   = 31'h2000_0000;
  localparam logic [OFF_W-1:0] OFS_SNAP  = 31'h2040_0000;
  localparam logic [OFF_W-1:0] OFS_ONT   = 31'h2100_0000;
  localparam logic [OFF_W-1:0] OFS_OFFT  = 31'h2100_0100;
  localparam logic [OFF_W-1:0] OFS_TEST  = 31'h2100_0400;
  localparam logic [OFF_W-1:0] OFS_CTL0  = 31'h2100_0C00;
  localparam logic [OFF_W-1:0] OFS_CTL1  = 31'h2100_0D00;
  localparam logic [OFF_W-1:0] OFS_SCR   = 31'h2000_0100;
  localparam int               STRIDE_LG = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CNT, SEL_SNAP, SEL_ONT, SEL_OFFT,
    SEL_TEST, SEL_CTL0, SEL_CTL1, SEL_SCR
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic [IDX_W-1:0] idx;
  } dec_t;

  typedef struct packed {
    logic              cmdLatch;
    logic              wrCommit;
    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/rtcs_serial_ctrl.sv
module rtcs_serial_ctrl
  import rtcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [WORD_W-1:0] rdData,
  output strobe_t           stb,
  output logic              miso
);
  localparam int CNT_W = $clog2(2*WORD_W+1);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(WORD_W-1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(2*WORD_W-1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(2*WORD_W);
  localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(WORD_W);

  logic              sclkQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] rxShift, rxNext, cmdReg, txShift;
  logic              misoR;
  logic              rise, fall, cmdDone, dataDone;

  assign rise     = sclk & ~sclkQ & ~csN;
  assign fall     = ~sclk & sclkQ & ~csN;
  assign rxNext   = {rxShift[WORD_W-2:0], mosi};
  assign cmdDone  = rise && (bitCnt == LAST_CMD);
  assign dataDone = rise && (bitCnt == LAST_DAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      bitCnt  <= '0;
      rxShift <= '0;
      cmdReg  <= '0;
      txShift <= '0;
      misoR   <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt  <= '0;
        txShift <= '0;
        misoR   <= 1'b0;
      end else begin
        if (rise && bitCnt != DONE_CNT) begin
          rxShift <= rxNext;
          bitCnt  <= bitCnt + 1'b1;
        end
        if (cmdDone) begin
          cmdReg  <= rxNext;
          txShift <= rxNext[WORD_W-1] ? '0 : rdData;
        end
        if (fall && bitCnt >= DATA_CNT) begin
          misoR   <= txShift[WORD_W-1];
          txShift <= {txShift[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    stb.cmdLatch = cmdDone & ~rxNext[WORD_W-1];
    stb.wrCommit = dataDone & cmdReg[WORD_W-1];
    stb.offset   = cmdDone ? rxNext[OFF_W-1:0] : cmdReg[OFF_W-1:0];
    stb.wrData   = rxNext;
  end

  assign miso = misoR;

  // R3: output returns to zero once the host releases chip select
  p_miso_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !miso);
  // R12: counter never runs past the end of a transfer
  p_bitcnt_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= DONE_CNT);
  // R2: a write commits in a single cycle per transfer
  p_commit_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCommit |=> !stb.wrCommit);
endmodule

// File: rtl/rtcs_addr_decode.sv
module rtcs_addr_decode
  import rtcs_pkg::*;
#(
  parameter int SCR_DEPTH = 16,
  parameter int TEST_N    = 4
) (
  input  logic [OFF_W-1:0] offset,
  output dec_t             dec
);
  logic [OFF_W-1:0] scrDiff, testDiff;
  logic             scrHit, testHit;

  always_comb begin
    scrDiff  = offset - OFS_SCR;
    testDiff = offset - OFS_TEST;
    scrHit   = (offset >= OFS_SCR) && (scrDiff[STRIDE_LG-1:0] == '0)
               && ((scrDiff >> STRIDE_LG) < OFF_W'(SCR_DEPTH));
    testHit  = (offset >= OFS_TEST) && (testDiff[STRIDE_LG-1:0] == '0)
               && ((testDiff >> STRIDE_LG) < OFF_W'(TEST_N));

    dec.sel = SEL_NONE;
    dec.idx = '0;
    if (offset == OFS_CNT)       dec.sel = SEL_CNT;
    else if (offset == OFS_SNAP) dec.sel = SEL_SNAP;
    else if (offset == OFS_ONT)  dec.sel = SEL_ONT;
    else if (offset == OFS_OFFT) dec.sel = SEL_OFFT;
    else if (offset == OFS_CTL0) dec.sel = SEL_CTL0;
    else if (offset == OFS_CTL1) dec.sel = SEL_CTL1;
    else if (testHit) begin
      dec.sel = SEL_TEST;
      dec.idx = testDiff[STRIDE_LG +: IDX_W];
    end else if (scrHit) begin
      dec.sel = SEL_SCR;
      dec.idx = scrDiff[STRIDE_LG +: IDX_W];
    end
  end
endmodule

// File: rtl/rtcs_regfile.sv
module rtcs_regfile
  import rtcs_pkg::*;
#(
  parameter logic [7:0]        REVISION  = 8'h01,
  parameter logic [WORD_W-1:0] TEST_INIT = 32'h0303_0303,
  parameter int                SCR_DEPTH = 16,
  parameter int                TEST_N    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  dec_t              dec,
  input  logic [WORD_W-1:0] counterIn,
  input  logic [WORD_W-1:0] snapshotIn,
  output logic [WORD_W-1:0] rdData,
  output logic              counterWrStb,
  output logic [WORD_W-1:0] counterWrData,
  output logic [WORD_W-1:0] onTimer,
  output logic [WORD_W-1:0] offTimer,
  output logic [WORD_W-1:0] ctl1
);
  localparam int SIDX_W = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1;
  localparam int TIDX_W = (TEST_N > 1) ? $clog2(TEST_N) : 1;

  logic [WORD_W-1:0] scr [SCR_DEPTH];
  logic [WORD_W-1:0] testReg [TEST_N];
  logic [WORD_W-9:0] ctl0Hi;
  logic [SIDX_W-1:0] sIdx;
  logic [TIDX_W-1:0] tIdx;
  logic              wrEn;

  assign sIdx = dec.idx[SIDX_W-1:0];
  assign tIdx = dec.idx[TIDX_W-1:0];
  assign wrEn = stb.wrCommit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SCR_DEPTH; i++) scr[i] <= '0;
    end else if (wrEn && dec.sel == SEL_SCR) begin
      scr[sIdx] <= stb.wrData;
    end
  end

  for (genvar t = 0; t < TEST_N; t++) begin : g_test
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) testReg[t] <= TEST_INIT;
      else if (wrEn && dec.sel == SEL_TEST && tIdx == TIDX_W'(t))
        testReg[t] <= stb.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onTimer       <= '0;
      offTimer      <= '0;
      ctl0Hi        <= '0;
      ctl1          <= '0;
      counterWrStb  <= 1'b0;
      counterWrData <= '0;
    end else begin
      counterWrStb <= 1'b0;
      if (wrEn) begin
        case (dec.sel)
          SEL_ONT:  onTimer  <= stb.wrData;
          SEL_OFFT: offTimer <= stb.wrData;
          SEL_CTL0: ctl0Hi   <= stb.wrData[WORD_W-1:8];
          SEL_CTL1: ctl1     <= stb.wrData;
          SEL_CNT: begin
            counterWrStb  <= 1'b1;
            counterWrData <= stb.wrData;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (dec.sel)
      SEL_CNT:  rdData = counterIn;
      SEL_SNAP: rdData = snapshotIn;
      SEL_ONT:  rdData = onTimer;
      SEL_OFFT: rdData = offTimer;
      SEL_TEST: rdData = testReg[tIdx];
      SEL_CTL0: rdData = {ctl0Hi, REVISION};
      SEL_CTL1: rdData = ctl1;
      SEL_SCR:  rdData = scr[sIdx];
      default:  rdData = '0;
    endcase
  end

  // R10: control 1 only moves on a committed write that targets it
  p_ctl1_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && dec.sel == SEL_CTL1) |=> $stable(ctl1));
  // R10: ON timer likewise
  p_ont_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && dec.sel == SEL_ONT) |=> $stable(onTimer));
  // R8: load strobe lasts a single cycle
  p_cnt_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    counterWrStb |=> !counterWrStb);
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
  import rtcs_pkg::*;
#(
  parameter logic [7:0] REVISION  = 8'h01,
  parameter int         SCR_DEPTH = 16,
  parameter int         TEST_N    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        mosi,
  output logic        miso,
  input  logic [31:0] counterIn,
  input  logic [31:0] snapshotIn,
  output logic        counterWrStb,
  output logic [31:0] counterWrData,
  output logic [31:0] onTimer,
  output logic [31:0] offTimer,
  output logic [31:0] ctl1
);
  strobe_t           stb;
  dec_t              dec;
  logic [WORD_W-1:0] rdData;

  rtcs_serial_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .rdData(rdData), .stb(stb), .miso(miso)
  );

  rtcs_addr_decode #(.SCR_DEPTH(SCR_DEPTH), .TEST_N(TEST_N)) u_dec (
    .offset(stb.offset), .dec(dec)
  );

  rtcs_regfile #(.REVISION(REVISION), .SCR_DEPTH(SCR_DEPTH), .TEST_N(TEST_N)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .dec(dec),
    .counterIn(counterIn), .snapshotIn(snapshotIn), .rdData(rdData),
    .counterWrStb(counterWrStb), .counterWrData(counterWrData),
    .onTimer(onTimer), .offTimer(offTimer), .ctl1(ctl1)
  );
endmodule

// File: tb/rtc_serial_slave_tb_top.sv
module rtc_serial_slave_tb_top;
  localparam logic [7:0] REV = 8'h01;
  localparam logic [30:0] A_CNT = 31'h2000_0000, A_SNAP = 31'h2040_0000,
    A_ONT = 31'h2100_0000, A_OFFT = 31'h2100_0100, A_TEST = 31'h2100_0400,
    A_CTL0 = 31'h2100_0C00, A_CTL1 = 31'h2100_0D00, A_SCR = 31'h2000_0100;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, counterWrStb;
  logic [31:0] counterIn = 32'h0000_1000, snapshotIn = 32'h0BAD_F00D;
  logic [31:0] counterWrData, onTimer, offTimer, ctl1;

  int checks = 0, fails = 0;
  bit monOn = 1'b0, finished = 1'b0, prevCs = 1'b1;
  bit expCntStb = 1'b0;
  logic [31:0] expCntData = '0;
  logic [31:0] mem [int];

  always #5 clk = ~clk;

  rtc_serial_slave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .counterIn(counterIn), .snapshotIn(snapshotIn), .counterWrStb(counterWrStb),
    .counterWrData(counterWrData), .onTimer(onTimer), .offTimer(offTimer), .ctl1(ctl1)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [30:0] off);
    if (off == A_CNT)  return counterIn;
    if (off == A_SNAP) return snapshotIn;
    if (!mem.exists(int'(off))) return '0;
    if (off == A_CTL0) return {mem[int'(off)][31:8], REV};
    return mem[int'(off)];
  endfunction

  // cycle-by-cycle comparison of the parallel outputs (R10, R8, R3)
  always @(negedge clk) begin
    if (monOn) begin
      check(onTimer  === mem[int'(A_ONT)],  "R10 onTimer",  onTimer,  mem[int'(A_ONT)]);
      check(offTimer === mem[int'(A_OFFT)], "R10 offTimer", offTimer, mem[int'(A_OFFT)]);
      check(ctl1     === mem[int'(A_CTL1)], "R10 ctl1",     ctl1,     mem[int'(A_CTL1)]);
      check(counterWrStb === expCntStb, "R8 strobe", {31'd0, counterWrStb}, {31'd0, expCntStb});
      if (expCntStb) check(counterWrData === expCntData, "R8 data", counterWrData, expCntData);
      if (csN && prevCs) check(miso === 1'b0, "R3 idle miso", {31'd0, miso}, 32'd0);
      prevCs = csN;
    end
  end

  task automatic xfer(input string req, input logic [31:0] cmd, input logic [31:0] wd,
                      input int nBits = 64, input bit bump = 1'b0, input logic [31:0] newCnt = '0);
    logic [31:0] rd = '0, expRd = '0;
    @(negedge clk); csN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      mosi = (i < 32) ? cmd[31-i] : (i < 64) ? wd[63-i] : 1'b1;
      repeat (3) @(negedge clk);
      if (i < 32 || (i < 64 && cmd[31]))
        check(miso === 1'b0, "R3 quiet miso", {31'd0, miso}, 32'd0);
      else if (i < 64) rd[63-i] = miso;
      if (i == 31 && bump) counterIn = newCnt;
      sclk = 1'b1;
      @(posedge clk);
      if (i == 31) expRd = mRead(cmd[30:0]);
      if (i == 63 && cmd[31]) begin
        if (cmd[30:0] == A_CNT) begin expCntStb = 1'b1; expCntData = wd; end
        else if (mem.exists(int'(cmd[30:0]))) mem[int'(cmd[30:0])] = wd;
        @(posedge clk); expCntStb = 1'b0;
      end
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (3) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    if (nBits >= 64 && !cmd[31]) check(rd === expRd, req, rd, expRd);
  endtask

  task automatic rd(input string req, input logic [30:0] off);
    xfer(req, {1'b0, off}, 32'h0);
  endtask
  task automatic wr(input logic [30:0] off, input logic [31:0] d);
    xfer("write", {1'b1, off}, d);
  endtask

  initial begin
    mem[int'(A_ONT)] = '0; mem[int'(A_OFFT)] = '0;
    mem[int'(A_CTL0)] = '0; mem[int'(A_CTL1)] = '0;
    for (int j = 0; j < 4; j++) mem[int'(A_TEST) + 256*j] = 32'h0303_0303;
    for (int j = 0; j < 16; j++) mem[int'(A_SCR) + 256*j] = '0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(miso === 1'b0 && counterWrStb === 1'b0, "R1 reset pins", {30'd0, miso, counterWrStb}, 32'd0);
    check(onTimer === '0 && offTimer === '0 && ctl1 === '0, "R1 reset regs", onTimer | offTimer | ctl1, 32'd0);
    monOn = 1'b1;
    for (int j = 0; j < 4; j++) rd("R1 test word", A_TEST + 31'(256*j));

    // R5: every scratch word, distinct patterns (R2 protocol throughout)
    for (int j = 0; j < 16; j++) wr(A_SCR + 31'(256*j), 32'hA5A5_0000 ^ (32'h0101_0101 * j) ^ {j[15:0], 16'h0});
    for (int j = 0; j < 16; j++) rd("R5 scratch", A_SCR + 31'(256*j));

    // R6: revision byte is fixed
    wr(A_CTL0, 32'hFFFF_FFFF);
    rd("R6 ctl0", A_CTL0);
    wr(A_CTL0, 32'h1234_5600);
    rd("R6 ctl0", A_CTL0);

    // R10: timers and control 1
    wr(A_ONT, 32'h8000_0E10);
    wr(A_OFFT, 32'h4000_003C);
    wr(A_CTL1, 32'h0001_0405);
    rd("R10 ctl1", A_CTL1);
    rd("R10 onT", A_ONT);

    // R7: unmapped offsets
    wr(31'h2000_0180, 32'hDEAD_BEEF);
    wr(31'h2000_1100, 32'hDEAD_BEEF);
    wr(31'h2100_0200, 32'hDEAD_BEEF);
    rd("R7 unmapped", 31'h2000_0180);
    rd("R7 unmapped", 31'h2000_1100);
    rd("R7 unmapped", 31'h2100_0200);
    rd("R7 neighbour", A_SCR);
    rd("R7 neighbour", A_SCR + 31'h0F00);
    rd("R7 neighbour", A_OFFT);

    // R4: exact compare on bits 30:0
    rd("R4 exact", 31'h6100_0D00);
    rd("R4 exact", 31'h2100_0D01);
    wr(31'h6100_0000, 32'h1111_1111);
    rd("R4 exact", A_ONT);

    // R8: counter read with same-cycle update, then counter write
    counterIn = 32'h0000_2000;
    rd("R8 counter", A_CNT);
    xfer("R8 counter collide", {1'b0, A_CNT}, 32'h0, 64, 1'b1, 32'h0000_2001);
    wr(A_CNT, 32'h5A5A_0001);
    counterIn = 32'h5A5A_0002;
    rd("R8 counter live", A_CNT);

    // R9: snapshot
    rd("R9 snapshot", A_SNAP);
    wr(A_SNAP, 32'h7777_7777);
    snapshotIn = 32'h0BAD_F00E;
    rd("R9 snapshot", A_SNAP);

    // R11: aborted writes
    xfer("R11 abort", {1'b1, A_CTL1}, 32'hFFFF_FFFF, 50);
    xfer("R11 abort", {1'b1, A_SCR}, 32'hFFFF_FFFF, 63);
    xfer("R11 abort", {1'b0, A_ONT}, 32'h0, 20);
    rd("R11 after abort", A_CTL1);
    rd("R11 after abort", A_SCR);

    // R12: extra clocks after bit 64
    xfer("R12 extra", {1'b1, A_OFFT}, 32'h0000_0055, 80);
    rd("R12 extra", A_OFFT);
    xfer("R12 extra read", {1'b0, A_CTL0}, 32'h0, 72);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule